// File: doc/BRIEF.md
# Programmable Down-Count Interval Timer

The block is a 32-bit local interval timer for an interrupt controller. Software loads a start value, picks a clock divider and programs a timer entry that holds an interrupt vector, a mask bit and a mode bit. The counter then counts down by one on every divided tick. When it passes from one to zero it raises a one-cycle interrupt request that carries the programmed vector, unless the entry is masked.

In one-shot mode the counter halts at zero. In periodic mode it reloads the start value on the tick after zero, so one period lasts start value plus one ticks. Register decoding sits outside the block. Three write strobes share one data bus, and every register, plus the live count, can be read on its own port.

Top module: `ival_timer`

## Requirements
- R1: After reset the current count, start value, divider register, `irq` and `irq_vec` are all zero, and `lvt_rd` reads 0x0001_0000 (masked, one-shot, vector 0).
- R2: A divider write keeps only bits 3, 1 and 0 of `wr_data`. `div_rd` returns `wr_data[3:0] & 4'hB`.
- R3: The divider code is {bit3, bit1, bit0}. The counter steps once every 2^((code+1) mod 8) clocks, so 0xB divides by 1, 0x0 by 2, 0x3 by 16 and 0x8 by 32.
- R4: A start-value write loads `cur_rd` with `wr_data` at the write edge and restarts the divider, so the first step comes exactly one divided period later.
- R5: In one-shot mode (entry bit 17 = 0) the count falls to zero, stays there and fires once.
- R6: In periodic mode (entry bit 17 = 1) the count after d ticks is start − (d mod (start+1)). A request fires on every step from 1 to 0.
- R7: With the mask bit (entry bit 16) set, no request is issued and counting goes on unchanged.
- R8: A request is a single-cycle `irq` pulse, registered on the edge where the count reaches zero. `irq_vec` equals entry bits 7:0.
- R9: A start value of zero leaves the timer halted with no request.
- R10: A timer-entry write during a count leaves the current count alone. The new mode, mask and vector apply from the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_we | input | 1 | Divider register write strobe |
| init_we | input | 1 | Start-value write strobe |
| lvt_we | input | 1 | Timer-entry write strobe |
| wr_data | input | 32 | Write data shared by all strobes |
| div_rd | output | 4 | Stored divider bits |
| init_rd | output | 32 | Stored start value |
| cur_rd | output | 32 | Live count |
| lvt_rd | output | 32 | Timer entry: vector 7:0, mask 16, periodic 17 |
| irq | output | 1 | One-cycle interrupt request |
| irq_vec | output | 8 | Vector of the latest request |

## Verification
The hardest case to reach is a timer-entry rewrite that lands between ticks while a count is in flight. The mode change must leave the count alone and still decide what happens at zero. The bench sets the divider to 1 and loads a one-shot count. On the very next cycle it rewrites the entry to periodic with a new vector. The scoreboard then expects exactly one request carrying the new vector, followed by a reload.

// File: rtl/ival_timer_pkg.sv
package ival_timer_pkg;
  localparam int VEC_W    = 8;
  localparam int SHIFT_W  = 3;
  localparam int PRE_W    = (1 << SHIFT_W) - 1;
  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;
  localparam logic [3:0] DIV_KEEP = 4'hB;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } lvt_t;

  function automatic logic [3:0] div_filter(input logic [3:0] raw);
    return raw & DIV_KEEP;
  endfunction

  function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + 3'd1;
  endfunction

  function automatic logic [PRE_W-1:0] pre_limit(input logic [SHIFT_W-1:0] sh);
    logic [PRE_W:0] one_hot;
    one_hot = {{PRE_W{1'b0}}, 1'b1} << sh;
    return one_hot[PRE_W-1:0] - 1'b1;
  endfunction
endpackage

// File: rtl/ival_prescaler.sv
module ival_prescaler
  import ival_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim  = pre_limit(shift);
  assign tick = ((pre_q & lim) == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) pre_q <= '0;
    else                 pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ival_counter.sv
module ival_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             run,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step   = tick && run && !load;
  assign expire = step && (cur == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
      run <= 1'b0;
    end else if (load) begin
      cur <= load_val;
      run <= (load_val != '0);
    end else if (step) begin
      if (cur == '0) begin
        if (periodic) cur <= reload_val;
        else          run <= 1'b0;
      end else begin
        cur <= cur - ONE;
        if (cur == ONE && !periodic) run <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ival_irq_gen.sv
module ival_irq_gen
  import ival_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  lvt_t             lvt,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vec
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq <= expire && !lvt.mask;
      if (expire && !lvt.mask) irq_vec <= lvt.vec;
    end
  end
endmodule

// File: rtl/ival_timer.sv
module ival_timer
  import ival_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_we,
  input  logic             init_we,
  input  logic             lvt_we,
  input  logic [CNT_W-1:0] wr_data,
  output logic [3:0]       div_rd,
  output logic [CNT_W-1:0] init_rd,
  output logic [CNT_W-1:0] cur_rd,
  output logic [CNT_W-1:0] lvt_rd,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vec
);
  logic [3:0]       div_q;
  logic [CNT_W-1:0] init_q;
  lvt_t             lvt_q;
  logic             tick_w;
  logic             run_w;
  logic             expire_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      init_q <= '0;
      lvt_q  <= '{periodic: 1'b0, mask: 1'b1, vec: '0};
    end else begin
      if (div_we)  div_q  <= div_filter(wr_data[3:0]);
      if (init_we) init_q <= wr_data;
      if (lvt_we) begin
        lvt_q.vec      <= wr_data[VEC_W-1:0];
        lvt_q.mask     <= wr_data[MASK_BIT];
        lvt_q.periodic <= wr_data[MODE_BIT];
      end
    end
  end

  ival_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(init_we),
    .shift(div_shift(div_q)),
    .tick (tick_w)
  );

  ival_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (init_we),
    .load_val  (wr_data),
    .reload_val(init_q),
    .tick      (tick_w),
    .periodic  (lvt_q.periodic),
    .cur       (cur_rd),
    .run       (run_w),
    .expire    (expire_w)
  );

  ival_irq_gen u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire_w),
    .lvt    (lvt_q),
    .irq    (irq),
    .irq_vec(irq_vec)
  );

  always_comb begin
    lvt_rd                = '0;
    lvt_rd[VEC_W-1:0]     = lvt_q.vec;
    lvt_rd[MASK_BIT]      = lvt_q.mask;
    lvt_rd[MODE_BIT]      = lvt_q.periodic;
  end

  assign div_rd  = div_q;
  assign init_rd = init_q;
endmodule

// File: rtl/ival_timer_chk.sv
module ival_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_we,
  input logic             init_we,
  input logic [CNT_W-1:0] wr_data,
  input logic [3:0]       div_rd,
  input logic [CNT_W-1:0] cur_rd,
  input logic [CNT_W-1:0] lvt_rd,
  input logic             irq,
  input logic             tick,
  input logic             run
);
  AST_DIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> div_rd == ($past(wr_data[3:0]) & 4'hB)); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !init_we) |=> $stable(cur_rd)); // R3
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    init_we |=> cur_rd == $past(wr_data)); // R4
  AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !init_we) |=> !run); // R5
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (init_we && wr_data == '0) |=> !run); // R9
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cur_rd == '0) && ($past(cur_rd) == CNT_W'(1))); // R6
  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !$past(lvt_rd[16])); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
endmodule

bind ival_timer ival_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .div_we (div_we),
  .init_we(init_we),
  .wr_data(wr_data),
  .div_rd (div_rd),
  .cur_rd (cur_rd),
  .lvt_rd (lvt_rd),
  .irq    (irq),
  .tick   (tick_w),
  .run    (run_w)
);

// File: tb/sim_ival_timer.sv
module sim_ival_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_we = 1'b0, init_we = 1'b0, lvt_we = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  div_rd;
  logic [31:0] init_rd, cur_rd, lvt_rd;
  logic        irq;
  logic [7:0]  irq_vec;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  typedef struct { int at; logic [7:0] vec; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ival_timer u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input logic [31:0] d);
    wr_data = d;
    div_we  = (kind == 0);
    lvt_we  = (kind == 1);
    init_we = (kind == 2);
    @(negedge clk);
    div_we = 0; lvt_we = 0; init_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_irq(input int at, input logic [7:0] v);
    exp_t e;
    e.at = at; e.vec = v;
    q.push_back(e);
  endtask

  // monitor: pops scoreboard on every request (R8)
  always @(negedge clk) begin
    if (rst_n && !done && irq) begin
      if (q.size() == 0) chk("R7/R9 unexpected irq", 32'(cyc), 32'hFFFF_FFFF);
      else begin
        exp_t e;
        e = q.pop_front();
        chk("R8 irq cycle", 32'(cyc), 32'(e.at));
        chk("R8 irq vector", {24'b0, irq_vec}, {24'b0, e.vec});
      end
    end
  end

  initial begin
    int c0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 cur", cur_rd, 0);
    chk("R1 init", init_rd, 0);
    chk("R1 div", {28'b0, div_rd}, 0);
    chk("R1 lvt", lvt_rd, 32'h0001_0000);
    chk("R1 irq", {31'b0, irq}, 0);

    wr(0, 32'h4);  chk("R2 bit2 dropped", {28'b0, div_rd}, 0);
    wr(0, 32'hFF); chk("R2 keep mask", {28'b0, div_rd}, 4'hB);

    // one-shot, divide by 1
    wr(1, 32'h41);
    wr(2, 5); c0 = cyc;
    expect_irq(c0 + 5, 8'h41);
    chk("R4 load", cur_rd, 5);
    for (int k = 1; k <= 5; k++) begin
      idle(1);
      chk("R5 countdown", cur_rd, 32'(5 - k));
    end
    idle(10);
    chk("R5 stays zero", cur_rd, 0);

    // divide by 16
    wr(0, 32'h3); wr(2, 3);
    idle(15); chk("R3 div16 before", cur_rd, 3);
    idle(1);  chk("R3 div16 step", cur_rd, 2);
    wr(2, 0);
    // divide by 32
    wr(0, 32'h8); wr(2, 2);
    idle(31); chk("R3 div32 before", cur_rd, 2);
    idle(1);  chk("R3 div32 step", cur_rd, 1);
    wr(2, 0);
    // divide by 2
    wr(0, 32'h0); wr(2, 7);
    idle(1); chk("R3 div2 before", cur_rd, 7);
    idle(1); chk("R3 div2 step", cur_rd, 6);
    wr(2, 0);

    // periodic
    wr(0, 32'hB); wr(1, 32'h0002_0022);
    wr(2, 2); c0 = cyc;
    expect_irq(c0 + 2, 8'h22); expect_irq(c0 + 5, 8'h22); expect_irq(c0 + 8, 8'h22);
    idle(1); chk("R6 p1", cur_rd, 1);
    idle(1); chk("R6 p0", cur_rd, 0);
    idle(1); chk("R6 reload", cur_rd, 2);
    idle(6); chk("R6 third period", cur_rd, 2);
    wr(2, 0);
    idle(2); chk("R6 all irqs seen", 32'(q.size()), 0);

    // masked periodic
    wr(1, 32'h0003_0022); wr(2, 1);
    idle(1); chk("R7 counts", cur_rd, 0);
    idle(1); chk("R7 reload", cur_rd, 1);
    idle(4); wr(2, 0);
    chk("R7 no pending", 32'(q.size()), 0);

    // zero start value
    wr(1, 32'h0002_0055); wr(2, 0);
    idle(20);
    chk("R9 halted", cur_rd, 0);
    chk("R9 entry readback", lvt_rd, 32'h0002_0055);

    // entry rewrite mid-count
    wr(1, 32'h66); wr(2, 4); c0 = cyc;
    expect_irq(c0 + 4, 8'h77);
    wr(1, 32'h0002_0077);
    chk("R10 count kept", cur_rd, 3);
    idle(3); chk("R10 zero", cur_rd, 0);
    idle(1); chk("R10 new mode reload", cur_rd, 4);
    wr(2, 0);
    idle(5);
    chk("R8 scoreboard empty", 32'(q.size()), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule